// File: doc/BRIEF.md
# Programmable Chip-Select Delay Generator

This block drives the active-low chip-select of one general-purpose memory bank on a multiplexed local bus. It is clocked by an internal fast clock that runs 2, 4 or 8 times faster than the bus clock. Because of this, the chip-select edge can be placed a quarter, a half, or a whole number of bus cycles after the moment the address has been latched.

A start strobe marks the cycle in which the latched address is valid. At that edge the block samples four configuration inputs:

- the divide ratio;
- a 2-bit delay code;
- an extended-delay flag;
- a relaxed-timing flag.

From these it works out a delay in fast-clock ticks and counts it down. It then holds chip-select low until an end-of-access strobe releases it. When a combination asks for an offset the fast clock cannot resolve, or one that is not offered at the current ratio, it is folded onto the nearest longer offset that is legal.

Top module: `cs_delay_gen`

## Requirements
- R1: Delay codes 2'b00 and 2'b01 (any flag setting) mean no offset: cs_n goes low on the same fast-clock edge that samples the start strobe. cs_n is never low while that strobe is being presented from idle.
- R2: ratio_sel selects the divide ratio: 2'b00 = 2, 2'b01 = 4, 2'b10 = 8, and 2'b11 behaves as 8.
- R3: With ext_dly = 0 and code 2'b10, the offset is ratio/4 ticks at ratio 4 or 8. At ratio 2 it becomes a half cycle (1 tick).
- R4: With ext_dly = 0 and code 2'b11, the offset is ratio/2 ticks.
- R5: With ext_dly = 1 and code 2'b10, the offset is one bus cycle (ratio ticks) at ratio 4. At ratio 2 or 8 it becomes two bus cycles (2 × ratio ticks).
- R6: With ext_dly = 1 and code 2'b11, the offset is 2 × ratio ticks, or 3 × ratio ticks when relax = 1. The relax input has no effect in any other combination.
- R7: For an offset of D ticks (D ≥ 1), cs_n goes low on the D-th edge after the edge that samples the start strobe. The configuration inputs are sampled only at that start edge.
- R8: access_end drives cs_n high on the next edge and cancels a pending count. When it arrives together with a start strobe in idle, access_end wins and no access begins.
- R9: A start strobe that arrives while a count is pending, or while cs_n is low, is ignored. cs_n stays low until access_end.
- R10: Reset (rst_n low, asynchronous) drives cs_n high and clears the delay counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_sel | input | 2 | Fast-to-bus clock ratio select |
| dly_code | input | 2 | Chip-select assertion delay code |
| ext_dly | input | 1 | Extended (whole-cycle) delay flag |
| relax | input | 1 | Relaxed-timing flag, lengthens the longest delay |
| addr_latched | input | 1 | Start strobe, one cycle, address is latched |
| access_end | input | 1 | End-of-access strobe |
| cs_n | output | 1 | Active-low chip-select |

## Verification
The hardest situations to reach from the ports are the ones where a strobe lands in the middle of a pending count:

- an end strobe that must cancel a count still running;
- a second start that must be ignored;
- configuration inputs that change after the start edge.

The bench reaches these with the 24-tick offset (ratio 8, extended, relaxed), which leaves a wide window. Inside that window it injects end strobes, repeat starts and changed configuration, then times the chip-select edge from the first start. A full sweep over every ratio, code and flag setting covers each folding rule.

// File: rtl/cs_dly_pkg.sv
package cs_dly_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_WAIT = 2'b01,
        ST_ON   = 2'b10
    } cs_state_e;

    localparam logic [1:0] CODE_NONE  = 2'b00;
    localparam logic [1:0] CODE_NONE2 = 2'b01;
    localparam logic [1:0] CODE_SHORT = 2'b10;
    localparam logic [1:0] CODE_LONG  = 2'b11;

    localparam logic [1:0] SEL_DIV2 = 2'b00;
    localparam logic [1:0] SEL_DIV4 = 2'b01;
    localparam logic [1:0] SEL_DIV8 = 2'b10;

endpackage

// File: rtl/cs_ratio_dec.sv
module cs_ratio_dec #(
    parameter int SEL_W     = 2,
    parameter int MAX_LOG2  = 3,
    parameter int CNT_W     = 5
) (
    input  logic [SEL_W-1:0] ratio_sel,
    output logic [CNT_W-1:0] ratio_ticks,
    output logic             is_div2,
    output logic             is_div4
);
    localparam int SHIFT_W = $clog2(MAX_LOG2 + 1);

    logic [SHIFT_W-1:0] shift_w;

    always_comb begin
        // Selector value n picks 2^(n+1), saturating at the largest ratio.
        if (32'(ratio_sel) + 1 >= MAX_LOG2) begin
            shift_w = SHIFT_W'(MAX_LOG2);
        end else begin
            shift_w = SHIFT_W'(32'(ratio_sel) + 1);
        end
        ratio_ticks = CNT_W'(1) << shift_w;
        is_div2     = (shift_w == SHIFT_W'(1));
        is_div4     = (shift_w == SHIFT_W'(2));
    end
endmodule

// File: rtl/cs_delay_calc.sv
module cs_delay_calc
    import cs_dly_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic [CNT_W-1:0] ratio_ticks,
    input  logic             is_div2,
    input  logic             is_div4,
    input  logic [1:0]       dly_code,
    input  logic             ext_dly,
    input  logic             relax,
    output logic [CNT_W-1:0] dly_ticks
);
    logic [CNT_W-1:0] quarter_w;
    logic [CNT_W-1:0] half_w;
    logic [CNT_W-1:0] double_w;
    logic [CNT_W-1:0] triple_w;

    always_comb begin
        half_w    = ratio_ticks >> 1;
        // A quarter cannot be resolved at ratio 2: fold to a half.
        quarter_w = is_div2 ? half_w : (ratio_ticks >> 2);
        double_w  = ratio_ticks << 1;
        triple_w  = double_w + ratio_ticks;

        dly_ticks = '0;
        unique case (dly_code)
            CODE_NONE, CODE_NONE2: dly_ticks = '0;
            CODE_SHORT: begin
                if (!ext_dly) begin
                    dly_ticks = quarter_w;
                end else if (is_div4) begin
                    dly_ticks = ratio_ticks;
                end else begin
                    dly_ticks = double_w;
                end
            end
            CODE_LONG: begin
                if (!ext_dly) begin
                    dly_ticks = half_w;
                end else if (relax) begin
                    dly_ticks = triple_w;
                end else begin
                    dly_ticks = double_w;
                end
            end
            default: dly_ticks = '0;
        endcase
    end
endmodule

// File: rtl/cs_seq.sv
module cs_seq
    import cs_dly_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             access_end,
    input  logic [CNT_W-1:0] dly_ticks,
    output logic             cs_n,
    output cs_state_e        state,
    output logic [CNT_W-1:0] cnt
);
    typedef struct packed {
        cs_state_e        state;
        logic [CNT_W-1:0] cnt;
        logic             cs_n;
    } seq_t;

    seq_t seq_d;
    seq_t seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.state)
            ST_IDLE: begin
                if (start && !access_end) begin
                    if (dly_ticks == '0) begin
                        seq_d.state = ST_ON;
                        seq_d.cs_n  = 1'b0;
                    end else begin
                        seq_d.state = ST_WAIT;
                        seq_d.cnt   = dly_ticks;
                    end
                end
            end
            ST_WAIT: begin
                if (access_end) begin
                    seq_d.state = ST_IDLE;
                    seq_d.cnt   = '0;
                end else if (seq_q.cnt == CNT_W'(1)) begin
                    seq_d.state = ST_ON;
                    seq_d.cnt   = '0;
                    seq_d.cs_n  = 1'b0;
                end else begin
                    seq_d.cnt = seq_q.cnt - CNT_W'(1);
                end
            end
            ST_ON: begin
                if (access_end) begin
                    seq_d.state = ST_IDLE;
                    seq_d.cs_n  = 1'b1;
                end
            end
            default: begin
                seq_d.state = ST_IDLE;
                seq_d.cnt   = '0;
                seq_d.cs_n  = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.state <= ST_IDLE;
            seq_q.cnt   <= '0;
            seq_q.cs_n  <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign cs_n  = seq_q.cs_n;
    assign state = seq_q.state;
    assign cnt   = seq_q.cnt;
endmodule

// File: rtl/cs_delay_gen.sv
module cs_delay_gen
    import cs_dly_pkg::*;
#(
    parameter int MAX_LOG2 = 3,
    parameter int MAX_MULT = 3,
    parameter int SEL_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] ratio_sel,
    input  logic [1:0]       dly_code,
    input  logic             ext_dly,
    input  logic             relax,
    input  logic             addr_latched,
    input  logic             access_end,
    output logic             cs_n
);
    localparam int MAX_RATIO = 1 << MAX_LOG2;
    localparam int MAX_TICKS = MAX_MULT * MAX_RATIO;
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);

    logic [CNT_W-1:0] ratio_ticks;
    logic             is_div2;
    logic             is_div4;
    logic [CNT_W-1:0] dly_ticks;
    cs_state_e        seq_state;
    logic [CNT_W-1:0] seq_cnt;

    cs_ratio_dec #(
        .SEL_W    (SEL_W),
        .MAX_LOG2 (MAX_LOG2),
        .CNT_W    (CNT_W)
    ) ratio_i (
        .ratio_sel   (ratio_sel),
        .ratio_ticks (ratio_ticks),
        .is_div2     (is_div2),
        .is_div4     (is_div4)
    );

    cs_delay_calc #(
        .CNT_W (CNT_W)
    ) calc_i (
        .ratio_ticks (ratio_ticks),
        .is_div2     (is_div2),
        .is_div4     (is_div4),
        .dly_code    (dly_code),
        .ext_dly     (ext_dly),
        .relax       (relax),
        .dly_ticks   (dly_ticks)
    );

    cs_seq #(
        .CNT_W (CNT_W)
    ) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (addr_latched),
        .access_end (access_end),
        .dly_ticks  (dly_ticks),
        .cs_n       (cs_n),
        .state      (seq_state),
        .cnt        (seq_cnt)
    );
endmodule

// File: rtl/cs_delay_chk.sv
module cs_delay_chk
    import cs_dly_pkg::*;
#(
    parameter int CNT_W     = 5,
    parameter int MAX_TICKS = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             addr_latched,
    input  logic             access_end,
    input  logic             cs_n,
    input  cs_state_e        seq_state,
    input  logic [CNT_W-1:0] seq_cnt,
    input  logic [CNT_W-1:0] dly_ticks
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (cs_n && seq_cnt == '0));                                   // R10

    AST_ZERO_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_latched && seq_state == ST_IDLE && !access_end && dly_ticks == '0)
        |=> !cs_n);                                                            // R1

    AST_NOT_DURING_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_latched && seq_state == ST_IDLE) |-> cs_n);                      // R1

    AST_LOAD_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_latched && seq_state == ST_IDLE && !access_end && dly_ticks != '0)
        |=> (cs_n && seq_cnt == $past(dly_ticks)));                            // R7

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_WAIT && seq_cnt > CNT_W'(1) && !access_end)
        |=> (cs_n && seq_cnt == $past(seq_cnt) - CNT_W'(1)));                  // R7

    AST_END_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        access_end |=> cs_n);                                                  // R8

    AST_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !access_end) |=> !cs_n);                                     // R9

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        32'(seq_cnt) <= MAX_TICKS);                                            // R6
endmodule

bind cs_delay_gen cs_delay_chk #(
    .CNT_W     (CNT_W),
    .MAX_TICKS (MAX_TICKS)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr_latched (addr_latched),
    .access_end   (access_end),
    .cs_n         (cs_n),
    .seq_state    (seq_state),
    .seq_cnt      (seq_cnt),
    .dly_ticks    (dly_ticks)
);

// File: tb/cs_delay_gen_tb_top.sv
module cs_delay_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] ratio_sel = 2'b00;
    logic [1:0] dly_code = 2'b00;
    logic       ext_dly = 1'b0;
    logic       relax = 1'b0;
    logic       addr_latched = 1'b0;
    logic       access_end = 1'b0;
    logic       cs_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    cs_delay_gen dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .ratio_sel    (ratio_sel),
        .dly_code     (dly_code),
        .ext_dly      (ext_dly),
        .relax        (relax),
        .addr_latched (addr_latched),
        .access_end   (access_end),
        .cs_n         (cs_n)
    );

    // Expected offset in ticks, written from the requirements.
    function automatic int exp_ticks(input logic [1:0] sel, input logic [1:0] code,
                                     input logic ext, input logic rlx);
        int r;
        r = (sel == 2'b00) ? 2 : (sel == 2'b01) ? 4 : 8;      // R2
        if (code[1] == 1'b0) return 0;                         // R1
        if (!ext) begin
            if (code == 2'b10) return (r == 2) ? 1 : r / 4;    // R3
            return r / 2;                                       // R4
        end
        if (code == 2'b10) return (r == 4) ? r : 2 * r;        // R5
        return rlx ? 3 * r : 2 * r;                             // R6
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic set_cfg(input logic [1:0] sel, input logic [1:0] code,
                           input logic ext, input logic rlx);
        ratio_sel = sel;
        dly_code  = code;
        ext_dly   = ext;
        relax     = rlx;
    endtask

    // Present a one-cycle start strobe; returns at the negedge after its edge.
    task automatic pulse_start();
        addr_latched = 1'b1;
        @(negedge clk);
        addr_latched = 1'b0;
    endtask

    task automatic pulse_end();
        access_end = 1'b1;
        @(negedge clk);
        access_end = 1'b0;
    endtask

    task automatic wait_low(output int lat);
        lat = 0;
        while (cs_n && lat < 64) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(cs_n == 1'b1, "R10 reset cs_n", int'(cs_n), 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(cs_n == 1'b1, "R10 idle after reset", int'(cs_n), 1);
    endtask

    // Every ratio, code and flag combination: latency, then release. R2 R7
    task automatic t_sweep();
        for (int s = 0; s < 4; s++) begin
            for (int c = 0; c < 4; c++) begin
                for (int e = 0; e < 2; e++) begin
                    for (int x = 0; x < 2; x++) begin
                        int lat;
                        int expd;
                        string tag;
                        expd = exp_ticks(2'(s), 2'(c), 1'(e), 1'(x));
                        if (c < 2) tag = "R1";
                        else if (e == 0) tag = (c == 2) ? "R3" : "R4";
                        else tag = (c == 2) ? "R5" : "R6";
                        set_cfg(2'(s), 2'(c), 1'(e), 1'(x));
                        check(cs_n == 1'b1, "R1 high while strobe presented", int'(cs_n), 1);
                        pulse_start();
                        wait_low(lat);
                        check(lat == expd, $sformatf("%s R2 R7 sel=%0d code=%0d ext=%0d rlx=%0d",
                              tag, s, c, e, x), lat, expd);
                        repeat (2) @(negedge clk);
                        pulse_end();
                        check(cs_n == 1'b1, "R8 release after end", int'(cs_n), 1);
                        @(negedge clk);
                    end
                end
            end
        end
    endtask

    // End strobe during a long pending count cancels it. R8
    task automatic t_abort();
        int lows = 0;
        set_cfg(2'b10, 2'b11, 1'b1, 1'b1);
        pulse_start();
        repeat (5) @(negedge clk);
        pulse_end();
        for (int i = 0; i < 30; i++) begin
            if (!cs_n) lows++;
            @(negedge clk);
        end
        check(lows == 0, "R8 abort pending count", lows, 0);
    endtask

    // Repeat start during the count and while asserted is ignored. R9
    task automatic t_restart();
        int lat = 0;
        set_cfg(2'b10, 2'b11, 1'b1, 1'b0);
        pulse_start();
        set_cfg(2'b00, 2'b00, 1'b0, 1'b0);
        while (cs_n && lat < 64) begin
            if (lat == 3) addr_latched = 1'b1;
            @(negedge clk);
            addr_latched = 1'b0;
            lat++;
        end
        check(lat == 16, "R9 restart during count ignored", lat, 16);
        pulse_start();
        repeat (4) @(negedge clk);
        check(cs_n == 1'b0, "R9 start while asserted ignored", int'(cs_n), 0);
        pulse_end();
        check(cs_n == 1'b1, "R9 release after end", int'(cs_n), 1);
        @(negedge clk);
    endtask

    // Configuration changed after the start edge has no effect. R7
    task automatic t_cfg_change();
        int lat;
        set_cfg(2'b01, 2'b10, 1'b1, 1'b0);
        pulse_start();
        set_cfg(2'b10, 2'b11, 1'b1, 1'b1);
        wait_low(lat);
        check(lat == 4, "R7 config sampled at start only", lat, 4);
        pulse_end();
        @(negedge clk);
    endtask

    // Start and end together in idle: end wins, nothing begins. R8
    task automatic t_same_cycle();
        int lows = 0;
        set_cfg(2'b00, 2'b00, 1'b0, 1'b0);
        addr_latched = 1'b1;
        access_end   = 1'b1;
        @(negedge clk);
        addr_latched = 1'b0;
        access_end   = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (!cs_n) lows++;
            @(negedge clk);
        end
        check(lows == 0, "R8 end wins over start", lows, 0);
    endtask

    initial begin
        t_reset();
        t_sweep();
        t_abort();
        t_restart();
        t_cfg_change();
        t_same_cycle();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule